// File: doc/BRIEF.md
# Serial Port Control and Data Register Unit

This block holds the two software-visible registers of a byte-wide serial port that sits on a small processor's memory-mapped I/O bus: a data byte and a control byte. Software starts a transfer by writing the control byte with the start flag and the internal-clock flag both set. The block then counts down a fixed number of enabled system clock cycles. The count is short when the enhanced mode input is high and the speed bit is set, and long in every other case.

When the count runs out, the start flag clears and the data byte becomes all ones, because no link partner drives the line. A one-cycle interrupt request pulse is also emitted for an external interrupt flag register to latch. A control write that does not request a start cancels any transfer in flight without raising an interrupt.

The register port is single-cycle. Writes are taken on the clock edge where the write strobe is high, and read data follows the address combinationally. The mode input selects the reset value of the control byte and whether the speed bit is forced high.

Top module: `serial_ctl_regs`

## Requirements
- R1: While reset is held, and right after it ends, the control byte reads 0x7E when the enhanced mode input is low and 0x7C when it is high. The data byte reads 0x00, and the interrupt output is low.
- R2: Control bits 6 down to 2 always read as 1. Bit 7 (start/busy), bit 1 (speed) and bit 0 (1 = internal clock) read back as stored.
- R3: When the enhanced mode input is low, every control write stores bit 1 as 1, whatever the written data.
- R4: A control write at offset 0x02 with bits 7 and 0 both set starts a transfer. If the enhanced mode input is high and the written bit 1 is set, the transfer completes on the 128th enabled cycle after the write.
- R5: Every other starting write completes on the 4096th enabled cycle after the write.
- R6: A control write without both bits 7 and 0 set abandons a transfer in progress. No interrupt follows, and the data byte keeps its value.
- R7: On completion, control bit 7 reads 0 and the data byte reads 0xFF. The interrupt output is high for exactly the one cycle after the completing edge.
- R8: The countdown advances only on edges where the cycle enable input is high.
- R9: A starting write made while a transfer is busy restarts the full count from that write.
- R10: The data byte at offset 0x01 is written and read back directly. Offsets other than 0x01 and 0x02 read 0x00.
- R11: When a data write falls on the same edge as a completion, the completion's 0xFF is the value stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_mode | input | 1 | Enhanced mode select |
| cyc_en | input | 1 | Cycle enable for the countdown |
| addr | input | 8 | Register offset |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| irq_o | output | 1 | One-cycle serial interrupt request |

## Verification
The hardest situation to reach from the ports is a data write that lands on exactly the edge where the countdown expires. The bench reaches it by counting enabled edges from the starting write and placing the data write on the 128th. It reaches the cancel and restart cases the same way, by placing control writes at known counts partway through a transfer and then waiting well past the original completion point. The sweep of every control value in both modes runs the abandon path on each starting value, because every write is followed by a cancelling write of zero.

// File: rtl/serial_ctl_regs.sv
module serial_ctl_regs #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'h01,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h02,
  parameter int FAST_CYCLES = 128,
  parameter int SLOW_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enh_mode,
  input  logic              cyc_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              irq_o
);
  localparam int MAX_CYCLES = (SLOW_CYCLES > FAST_CYCLES) ? SLOW_CYCLES : FAST_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);
  localparam logic [7:0] FIXED_ONES = 8'h7C;
  localparam logic [7:0] BASIC_RST  = 8'h7E;
  localparam logic [7:0] ENH_RST    = 8'h7C;
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYCLES);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYCLES);

  logic [7:0]       ctrl_q, data_q;
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;

  wire       ctrl_wr = wr_en && (addr == CTRL_OFS);
  wire       data_wr = wr_en && (addr == DATA_OFS);
  wire [7:0] ctrl_in = wdata | (enh_mode ? 8'h00 : 8'h02);
  wire       start   = ctrl_in[7] & ctrl_in[0];
  wire       fast    = enh_mode & ctrl_in[1];
  wire       running = cnt_q != '0;
  wire       done    = !ctrl_wr && cyc_en && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= enh_mode ? ENH_RST : BASIC_RST;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= done;
      if (ctrl_wr) begin
        ctrl_q <= ctrl_in | FIXED_ONES;
        cnt_q  <= start ? (fast ? FAST_LD : SLOW_LD) : '0;
      end else if (cyc_en && running) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (done) ctrl_q[7] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          data_q <= 8'h00;
    else if (done)    data_q <= 8'hFF;
    else if (data_wr) data_q <= wdata;
  end

  assign irq_o = irq_q;
  assign rdata = (addr == DATA_OFS) ? data_q :
                 (addr == CTRL_OFS) ? ctrl_q : 8'h00;
endmodule

module serial_ctl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'h02,
  parameter int FAST_CYCLES = 128,
  parameter int CNT_W = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              enh_mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        wdata,
  input logic              irq_o,
  input logic [7:0]        ctrl_q,
  input logic [7:0]        data_q,
  input logic [CNT_W-1:0]  cnt_q
);
  p_fixed_ones_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> ctrl_q[6:2] == 5'h1F);
  p_basic_speed_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_OFS && !enh_mode) |=> ctrl_q[1]);
  p_fast_load_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_OFS && enh_mode && wdata[7] && wdata[1] && wdata[0])
    |=> cnt_q == CNT_W'(FAST_CYCLES));
  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == CTRL_OFS && !(wdata[7] && wdata[0])) |=> !irq_o);
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);
  p_done_state_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (!ctrl_q[7] && data_q == 8'hFF));
endmodule

bind serial_ctl_regs serial_ctl_regs_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .FAST_CYCLES(FAST_CYCLES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .enh_mode(enh_mode), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .irq_o(irq_o), .ctrl_q(ctrl_q), .data_q(data_q), .cnt_q(cnt_q)
);

// File: tb/serial_ctl_regs_bench.sv
`timescale 1ns/1ps
module serial_ctl_regs_bench;
  logic clk = 0, rst = 1, enh_mode = 0, cyc_en = 1, wr_en = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic [7:0] rdata;
  logic irq_o;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_ctl_regs u_serial_ctl_regs (
    .clk(clk), .rst(rst), .enh_mode(enh_mode), .cyc_en(cyc_en), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    addr = a; #0.1; v = rdata;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_reset(logic mode);
    enh_mode = mode; rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic expect_done(string req, logic [7:0] ctrl_exp);
    logic [7:0] v;
    check(req, {7'h0, irq_o}, 8'h01);
    rd(8'h02, v); check(req, v, ctrl_exp & 8'h7F);
    rd(8'h01, v); check(req, v, 8'hFF);
    @(negedge clk);
    check(req, {7'h0, irq_o}, 8'h00);
  endtask

  task automatic timed(string req, logic mode, logic [7:0] val, int n);
    logic [7:0] v, exp;
    exp = val | (mode ? 8'h00 : 8'h02) | 8'h7C;
    do_reset(mode);
    wr(8'h01, 8'h3C);
    wr(8'h02, val);
    run(n - 1);
    check(req, {7'h0, irq_o}, 8'h00);
    rd(8'h02, v); check(req, v, exp);
    rd(8'h01, v); check(req, v, 8'h3C);
    @(negedge clk);
    expect_done(req, exp);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      do_reset(m[0]);
      rd(8'h02, v); check("R1", v, m[0] ? 8'h7C : 8'h7E);
      rd(8'h01, v); check("R1", v, 8'h00);
      check("R1", {7'h0, irq_o}, 8'h00);
      for (int x = 0; x < 256; x++) begin
        wr(8'h02, x[7:0]);
        rd(8'h02, v);
        check(m[0] ? "R2" : "R3", v, x[7:0] | (m[0] ? 8'h00 : 8'h02) | 8'h7C);
        wr(8'h02, 8'h00);
        check("R6", {7'h0, irq_o}, 8'h00);
      end
      rd(8'h01, v); check("R6", v, 8'h00);
    end

    // R10 data register and unmapped offsets
    do_reset(0);
    for (int d = 0; d < 256; d += 37) begin
      wr(8'h01, d[7:0]); rd(8'h01, v); check("R10", v, d[7:0]);
    end
    for (int a = 3; a < 256; a += 50) begin
      rd(a[7:0], v); check("R10", v, 8'h00);
    end

    timed("R4", 1'b1, 8'h83, 128);
    timed("R5", 1'b1, 8'h81, 4096);
    timed("R5", 1'b0, 8'h83, 4096);
    timed("R5", 1'b0, 8'h81, 4096);

    // R6 abort mid-transfer
    do_reset(1);
    wr(8'h01, 8'h5A);
    wr(8'h02, 8'h83);
    run(60);
    wr(8'h02, 8'h03);
    for (int i = 0; i < 200; i++) begin
      if (irq_o) begin check("R6", 8'h01, 8'h00); break; end
      @(negedge clk);
    end
    rd(8'h01, v); check("R6", v, 8'h5A);
    rd(8'h02, v); check("R6", v, 8'h7F);

    // R9 restart while busy
    do_reset(1);
    wr(8'h02, 8'h83);
    run(100);
    wr(8'h02, 8'h83);
    run(127);
    check("R9", {7'h0, irq_o}, 8'h00);
    @(negedge clk);
    expect_done("R9", 8'hFF);

    // R8 countdown holds while enable is low
    do_reset(1);
    wr(8'h02, 8'h83);
    for (int k = 0; k < 128; k++) begin
      cyc_en = 0; run(2);
      cyc_en = 1;
      if (k == 127) check("R8", {7'h0, irq_o}, 8'h00);
      @(negedge clk);
    end
    expect_done("R8", 8'hFF);

    // R11 data write on the completion edge
    do_reset(1);
    wr(8'h01, 8'h11);
    wr(8'h02, 8'h83);
    run(127);
    wr(8'h01, 8'h55);
    expect_done("R11", 8'hFF);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule